// File: doc/BRIEF.md
# SPI Command/Data Transmit Queue

This block buffers outgoing work for a SPI controller. Every entry couples a command word, which carries the chip-select and transfer attributes, with the data word to send. A host or DMA engine loads one pair per push. When a transfer starts, the shift logic takes the oldest pair from the head. Pairs leave the queue in only two ways: a pop into the shift register, or a flush.

The block reports how many valid entries it holds and the index of the head entry. A fill flag asks for more data and can be routed to either a DMA request or an interrupt. An underflow flag records that the shift logic asked for an entry while the queue was empty. A single-entry mode turns the queue into a plain double buffer, and the status outputs then report as a one-entry queue would. This mode must be chosen while the queue is empty and has not yet been used.

Top module: `spi_txq`

## Requirements
- R1: After reset, count_o is 0, next_ptr_o is 0, pop_valid_o is 0, fill_flag_o is 1 and uflow_flag_o is 0.
- R2: A push stores push_cmd_i and push_dat_i together. Entries come out in push order. While count_o is nonzero, pop_cmd_o and pop_dat_o show the head entry in the same cycle.
- R3: On each clock edge, count_o rises by one for an accepted push and falls by one for an accepted pop. It stays the same when both happen in one cycle. It never exceeds the effective depth: DEPTH (4) normally, or 1 in single-entry mode.
- R4: A push while the queue is full is ignored. count_o, next_ptr_o and the head entry are unchanged.
- R5: next_ptr_o is the head index counted from entry 0. It advances by one on every accepted pop and wraps from DEPTH-1 to 0.
- R6: In the cycle after any update that leaves count_o below the effective depth, fill_flag_o is 1.
- R7: While the queue is full, fill_flag_o clears on the next edge if either of two things happens: a push with push_dma_i=1 happens, or fill_clr_i is 1. A push with push_dma_i=0 that fills the queue leaves the flag set.
- R8: With fill_dma_sel_i=1 the fill flag drives fill_dma_req_o and fill_irq_o is 0. With fill_dma_sel_i=0 the flag drives fill_irq_o and fill_dma_req_o is 0.
- R9: If pop_i is asserted while count_o is 0 and no flush is requested, uflow_flag_o is set on the next edge and count_o stays 0. uflow_clr_i=1 clears the flag.
- R10: flush_i sets count_o to 0 and both pointers to entry 0 on the next edge. It overrides a push or pop requested in the same cycle.
- R11: With fifo_dis_i=1, the block holds one entry. A second push is ignored, and the count and fill flag behave as a one-entry queue would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_dis_i | input | 1 | Single-entry (double-buffer) mode |
| flush_i | input | 1 | Discard all entries |
| push_i | input | 1 | Push request |
| push_dma_i | input | 1 | Push comes from DMA |
| push_cmd_i | input | CMD_W | Command word to push |
| push_dat_i | input | DAT_W | Data word to push |
| pop_i | input | 1 | Shift logic takes the head entry |
| pop_valid_o | output | 1 | Head entry is valid |
| pop_cmd_o | output | CMD_W | Head command word |
| pop_dat_o | output | DAT_W | Head data word |
| count_o | output | CNT_W | Valid entry count |
| next_ptr_o | output | PTR_W | Head entry index |
| fill_clr_i | input | 1 | Write-1 clear of the fill flag |
| fill_dma_sel_i | input | 1 | Route the fill flag to DMA (1) or IRQ (0) |
| fill_flag_o | output | 1 | Fill flag |
| fill_dma_req_o | output | 1 | DMA request |
| fill_irq_o | output | 1 | Interrupt request |
| uflow_clr_i | input | 1 | Write-1 clear of the underflow flag |
| uflow_flag_o | output | 1 | Underflow flag |

## Verification
The bench makes the pointers wrap past entry 3 while data is still queued. A wrap error would present the wrong head word. It fills the queue once with host pushes and once with a DMA push. A fill flag that clears on any filling push, or on none, would then break R7. It also issues push, pop and flush together, so a design that lets the push or pop through ends with a nonzero count. Finally, in single-entry mode it pushes twice, which exposes a design that still accepts four entries.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
  parameter int unsigned CMD_W = 16;
  parameter int unsigned DAT_W = 16;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic [DAT_W-1:0] dat;
  } txq_entry_t;
endpackage

// File: rtl/spi_txq_store.sv
module spi_txq_store
  import spi_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  txq_entry_t       wr_data_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output txq_entry_t       rd_data_o
);
  txq_entry_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      slot_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == PTR_W'(g))        slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/spi_txq_ptrs.sv
module spi_txq_ptrs #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PTR_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             single_i,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             push_ok_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             full_nxt_o
);
  logic [CNT_W-1:0] eff_depth, count_q, count_d;
  logic [PTR_W-1:0] wr_q, rd_q, last_idx;
  logic             pop_ok;

  assign eff_depth  = single_i ? CNT_W'(1) : CNT_W'(DEPTH);
  assign last_idx   = PTR_W'(eff_depth - CNT_W'(1));
  assign full_o     = (count_q == eff_depth);
  assign push_ok_o  = push_i && !full_o && !flush_i;
  assign pop_ok     = pop_i && (count_q != '0) && !flush_i;
  assign count_d    = flush_i ? '0 : count_q + CNT_W'(push_ok_o) - CNT_W'(pop_ok);
  assign full_nxt_o = (count_d == eff_depth);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p, input logic [PTR_W-1:0] lim);
    return (p == lim) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
    end else begin
      count_q <= count_d;
      if (flush_i) begin
        wr_q <= '0;
        rd_q <= '0;
      end else begin
        if (push_ok_o) wr_q <= bump(wr_q, last_idx);
        if (pop_ok)    rd_q <= bump(rd_q, last_idx);
      end
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = count_q;

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  assert_full_push_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> ($stable(count_q) && $stable(wr_q)));
  assert_flush_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0 && rd_q == '0 && wr_q == '0));
  assert_single_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_i |-> count_q <= CNT_W'(1));
endmodule

// File: rtl/spi_txq_flags.sv
module spi_txq_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_i,
  input  logic full_nxt_i,
  input  logic dma_push_i,
  input  logic fill_clr_i,
  input  logic dma_sel_i,
  input  logic uflow_set_i,
  input  logic uflow_clr_i,
  output logic fill_o,
  output logic dma_req_o,
  output logic irq_o,
  output logic uflow_o
);
  logic fill_q, uflow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= 1'b1;
      uflow_q <= 1'b0;
    end else begin
      if (!full_nxt_i)                    fill_q <= 1'b1;
      else if (dma_push_i || fill_clr_i)  fill_q <= 1'b0;
      if (uflow_set_i)                    uflow_q <= 1'b1;
      else if (uflow_clr_i)               uflow_q <= 1'b0;
    end
  end

  assign fill_o    = fill_q;
  assign uflow_o   = uflow_q;
  assign dma_req_o = fill_q && dma_sel_i;
  assign irq_o     = fill_q && !dma_sel_i;

  assert_fill_when_room_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_i |-> fill_q);
  assert_req_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_req_o, irq_o}));
  assert_uflow_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_set_i |=> uflow_q);
endmodule

// File: rtl/spi_txq.sv
module spi_txq
  import spi_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_dis_i,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             push_dma_i,
  input  logic [CMD_W-1:0] push_cmd_i,
  input  logic [DAT_W-1:0] push_dat_i,
  input  logic             pop_i,
  output logic             pop_valid_o,
  output logic [CMD_W-1:0] pop_cmd_o,
  output logic [DAT_W-1:0] pop_dat_o,
  output logic [CNT_W-1:0] count_o,
  output logic [PTR_W-1:0] next_ptr_o,
  input  logic             fill_clr_i,
  input  logic             fill_dma_sel_i,
  output logic             fill_flag_o,
  output logic             fill_dma_req_o,
  output logic             fill_irq_o,
  input  logic             uflow_clr_i,
  output logic             uflow_flag_o
);
  logic             push_ok, full, full_nxt;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  txq_entry_t       wr_entry, head;

  assign wr_entry = '{cmd: push_cmd_i, dat: push_dat_i};

  spi_txq_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk_i, .rst_ni,
    .single_i   (fifo_dis_i),
    .flush_i,
    .push_i,
    .pop_i,
    .push_ok_o  (push_ok),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .count_o    (count),
    .full_o     (full),
    .full_nxt_o (full_nxt)
  );

  spi_txq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i   (push_ok),
    .wr_idx_i  (wr_ptr),
    .wr_data_i (wr_entry),
    .rd_idx_i  (rd_ptr),
    .rd_data_o (head)
  );

  spi_txq_flags u_flags (
    .clk_i, .rst_ni,
    .full_i      (full),
    .full_nxt_i  (full_nxt),
    .dma_push_i  (push_i && push_dma_i),
    .fill_clr_i,
    .dma_sel_i   (fill_dma_sel_i),
    .uflow_set_i (pop_i && (count == '0) && !flush_i),
    .uflow_clr_i,
    .fill_o      (fill_flag_o),
    .dma_req_o   (fill_dma_req_o),
    .irq_o       (fill_irq_o),
    .uflow_o     (uflow_flag_o)
  );

  assign pop_valid_o = (count != '0);
  assign pop_cmd_o   = head.cmd;
  assign pop_dat_o   = head.dat;
  assign count_o     = count;
  assign next_ptr_o  = rd_ptr;
endmodule

// File: tb/spi_txq_bench.sv
`timescale 1ns/1ps
module spi_txq_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        fifo_dis, flush, push, push_dma, pop, fill_clr, dma_sel, uflow_clr;
  logic [15:0] push_cmd, push_dat, pop_cmd, pop_dat;
  logic        pop_valid, fill_flag, dma_req, irq, uflow;
  logic [2:0]  count;
  logic [1:0]  next_ptr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_txq u_spi_txq (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_dis_i(fifo_dis), .flush_i(flush),
    .push_i(push), .push_dma_i(push_dma), .push_cmd_i(push_cmd), .push_dat_i(push_dat),
    .pop_i(pop), .pop_valid_o(pop_valid), .pop_cmd_o(pop_cmd), .pop_dat_o(pop_dat),
    .count_o(count), .next_ptr_o(next_ptr), .fill_clr_i(fill_clr),
    .fill_dma_sel_i(dma_sel), .fill_flag_o(fill_flag), .fill_dma_req_o(dma_req),
    .fill_irq_o(irq), .uflow_clr_i(uflow_clr), .uflow_flag_o(uflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_push(input logic [15:0] c, input logic [15:0] d, input logic dma);
    push = 1'b1; push_cmd = c; push_dat = d; push_dma = dma;
    cyc();
    push = 1'b0; push_dma = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1;
    cyc();
    pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", 32'(count), 0);
    chk("R1 next_ptr", 32'(next_ptr), 0);
    chk("R1 pop_valid", 32'(pop_valid), 0);
    chk("R1 fill", 32'(fill_flag), 1);
    chk("R1 uflow", 32'(uflow), 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 3; i++) do_push(16'h0101 + 16'(i), 16'hA001 + 16'(i), 1'b0);
    chk("R3 count after 3 pushes", 32'(count), 3);
    chk("R6 fill with room", 32'(fill_flag), 1);
    for (int i = 0; i < 3; i++) begin
      chk("R2 head cmd", 32'(pop_cmd), 32'(16'h0101 + 16'(i)));
      chk("R2 head dat", 32'(pop_dat), 32'(16'hA001 + 16'(i)));
      chk("R5 next_ptr", 32'(next_ptr), 32'(i));
      do_pop();
    end
    chk("R3 count drained", 32'(count), 0);
    chk("R5 next_ptr after 3 pops", 32'(next_ptr), 3);
  endtask

  task automatic t_full();
    for (int i = 0; i < 4; i++) do_push(16'h0201 + 16'(i), 16'hB001 + 16'(i), 1'b0);
    chk("R3 count full", 32'(count), 4);
    chk("R7 host fill keeps flag", 32'(fill_flag), 1);
    do_push(16'h02FF, 16'hBFFF, 1'b0);
    chk("R4 count on full push", 32'(count), 4);
    chk("R4 next_ptr on full push", 32'(next_ptr), 3);
    chk("R4 head on full push", 32'(pop_cmd), 16'h0201);
    fill_clr = 1'b1; cyc(); fill_clr = 1'b0;
    chk("R7 host clear while full", 32'(fill_flag), 0);
    do_pop();
    chk("R6 fill after pop", 32'(fill_flag), 1);
    chk("R5 pointer wraps", 32'(next_ptr), 0);
    chk("R2 head after wrap", 32'(pop_cmd), 16'h0202);
    dma_sel = 1'b1;
    do_push(16'h0205, 16'hB005, 1'b1);
    chk("R7 dma fill clears flag", 32'(fill_flag), 0);
    chk("R8 dma_req low", 32'(dma_req), 0);
    do_pop();
    chk("R8 dma_req", 32'(dma_req), 1);
    chk("R8 irq masked", 32'(irq), 0);
    dma_sel = 1'b0; #1;
    chk("R8 irq", 32'(irq), 1);
    chk("R8 dma_req masked", 32'(dma_req), 0);
  endtask

  task automatic t_simul();
    push = 1'b1; push_cmd = 16'h0301; push_dat = 16'hC001; pop = 1'b1;
    cyc();
    push = 1'b0; pop = 1'b0;
    chk("R3 push+pop count", 32'(count), 3);
    chk("R2 head after push+pop", 32'(pop_cmd), 16'h0204);
  endtask

  task automatic t_flush();
    push = 1'b1; push_cmd = 16'h0401; pop = 1'b1; flush = 1'b1;
    cyc();
    push = 1'b0; pop = 1'b0; flush = 1'b0;
    chk("R10 count after flush", 32'(count), 0);
    chk("R10 next_ptr after flush", 32'(next_ptr), 0);
    chk("R10 pop_valid after flush", 32'(pop_valid), 0);
    chk("R10 fill after flush", 32'(fill_flag), 1);
    chk("R10 no underflow on flush", 32'(uflow), 0);
  endtask

  task automatic t_uflow();
    do_pop();
    chk("R9 uflow set", 32'(uflow), 1);
    chk("R9 count stays 0", 32'(count), 0);
    uflow_clr = 1'b1; cyc(); uflow_clr = 1'b0;
    chk("R9 uflow cleared", 32'(uflow), 0);
  endtask

  task automatic t_dis();
    fifo_dis = 1'b1;
    do_push(16'h0501, 16'hD001, 1'b0);
    chk("R11 count one", 32'(count), 1);
    chk("R11 host fill keeps flag", 32'(fill_flag), 1);
    do_push(16'h0502, 16'hD002, 1'b0);
    chk("R11 second push ignored", 32'(count), 1);
    chk("R11 head kept", 32'(pop_cmd), 16'h0501);
    do_pop();
    chk("R11 count empty", 32'(count), 0);
    chk("R11 fill after pop", 32'(fill_flag), 1);
    do_push(16'h0503, 16'hD003, 1'b1);
    chk("R11 dma fill clears flag", 32'(fill_flag), 0);
    chk("R11 head dat", 32'(pop_dat), 16'hD003);
    do_pop();
    flush = 1'b1; cyc(); flush = 1'b0;
    fifo_dis = 1'b0;
  endtask

  initial begin
    fifo_dis = 0; flush = 0; push = 0; push_dma = 0; pop = 0;
    fill_clr = 0; dma_sel = 0; uflow_clr = 0; push_cmd = '0; push_dat = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_order();
    t_full();
    t_simul();
    t_flush();
    t_uflow();
    t_dis();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule